// File: doc/BRIEF.md
# Sequential Access Detector for a Memory-Mapped Flash Data Port

This block sits beside the memory-mapped data port of a serial flash controller. It watches every access the port accepts and decides, in the same cycle, whether that access carries on from the one before it or has to start a fresh flash transaction. The flash sequencer uses the result to keep streaming data under one command or to close the current transaction and issue a new command.

An access counts as a continuation only when three things hold together. Its direction must match the previous accepted access, and so must its size. Its address must also be exactly the previous address plus the previous access size in bytes. Any mismatch raises a one-cycle restart pulse. A flush input, a reset, a reserved size code or an address that would wrap past the top of the address space also break the chain. The block records the accepted access so that it can judge the next one. It does not issue flash commands and does not move data.

Top module: `seq_access_detector`

## Requirements
- R1: For an accepted access (req_valid and req_ready both 1) that has the same direction and size as the previous accepted access, and whose address is the previous address plus the previous step, seq_flag is 1 and restart is 0 in that same cycle.
- R2: An accepted access whose req_write differs from that of the previous accepted access gives restart = 1 and seq_flag = 0.
- R3: An accepted access whose req_size differs from that of the previous accepted access gives restart = 1 and seq_flag = 0.
- R4: An accepted access whose address is not the expected next address (a gap, a repeat or a step backwards) gives restart = 1 and seq_flag = 0.
- R5: The step is set by the previous size code: 2'b00 byte adds 1, 2'b01 half-word adds 2, 2'b10 word adds 4.
- R6: The first accepted access after reset always gives restart = 1.
- R7: When req_valid or req_ready is 0, seq_flag and restart are both 0, and that cycle leaves the recorded previous access unchanged.
- R8: A flush cycle with no access makes the next accepted access give restart = 1. If the flush comes in the same cycle as an accepted access, that access gives restart = 1 and is still recorded, so the access after it can be sequential.
- R9: If the previous address plus the step carries out of the address width, the next access gives restart = 1, even when its address is the wrapped value.
- R10: Size code 2'b11 is reserved. Such an access gives restart = 1, and the access after it also gives restart = 1.
- R11: For every accepted access exactly one of seq_flag and restart is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | input | 1 | Port accepts the access this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| flush | input | 1 | Forget the recorded access |
| seq_flag | output | 1 | Accepted access continues the current burst |
| restart | output | 1 | Accepted access starts a new flash transaction |

## Verification
The only state in the block is the recorded previous access and its valid bit, and the recorded access is compared at the very next accepted access. A wrong stored address, direction or size therefore shows up at once as a restart pulse where seq_flag was expected, or the reverse. A stale valid bit, left set after a reset, flush or reserved size, shows up as a false seq_flag on the first access that follows. The directed sequences place each break condition straight after a clean sequential run, so that a fault shows on the very access that tests it.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic      is_write;
        acc_size_e size;
    } acc_kind_t;

    localparam int unsigned STEP_W = 3;

    function automatic logic [STEP_W-1:0] size_step(acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic size_legal(acc_size_e s);
        return s != SZ_RSVD;
    endfunction

endpackage

// File: rtl/seqdet_history.sv
module seqdet_history
    import seqdet_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  logic [ADDR_W-1:0] in_addr,
    input  acc_kind_t         in_kind,
    output logic              hist_valid,
    output logic [ADDR_W-1:0] hist_addr,
    output acc_kind_t         hist_kind
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_valid <= 1'b0;
            hist_addr  <= '0;
            hist_kind  <= '{is_write: 1'b0, size: SZ_BYTE};
        end else if (load) begin
            hist_valid <= size_legal(in_kind.size);
            hist_addr  <= in_addr;
            hist_kind  <= in_kind;
        end else if (clear) begin
            hist_valid <= 1'b0;
        end
    end

    // R7: a cycle without an accepted access keeps the record
    a_r7_hold_record: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(hist_addr) && $stable(hist_kind)));

    // R8: a flush on its own drops the record
    a_r8_flush_drops: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> !hist_valid);

    // R10: a reserved size never leaves a valid record
    a_r10_rsvd_invalid: assert property (@(posedge clk) disable iff (rst)
        (load && in_kind.size == SZ_RSVD) |=> !hist_valid);

endmodule

// File: rtl/seqdet_compare.sv
module seqdet_compare
    import seqdet_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              prev_valid,
    input  logic [ADDR_W-1:0] prev_addr,
    input  acc_kind_t         prev_kind,
    input  logic              force_break,
    input  logic [ADDR_W-1:0] cur_addr,
    input  acc_kind_t         cur_kind,
    output logic              follows
);

    localparam int unsigned SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] next_sum;
    logic             addr_ok;
    logic             kind_ok;

    always_comb begin
        next_sum = {1'b0, prev_addr} + SUM_W'(size_step(prev_kind.size));
        addr_ok  = !next_sum[ADDR_W] && (next_sum[ADDR_W-1:0] == cur_addr);
        kind_ok  = (prev_kind.is_write == cur_kind.is_write)
                && (prev_kind.size == cur_kind.size);
        follows  = prev_valid && !force_break && size_legal(cur_kind.size)
                && kind_ok && addr_ok;
    end

endmodule

// File: rtl/seq_access_detector.sv
module seq_access_detector
    import seqdet_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              flush,
    output logic              seq_flag,
    output logic              restart
);

    logic              accept;
    logic              follows;
    logic              hist_valid;
    logic [ADDR_W-1:0] hist_addr;
    acc_kind_t         hist_kind;
    acc_kind_t         cur_kind;

    assign accept   = req_valid && req_ready;
    assign cur_kind = '{is_write: req_write, size: acc_size_e'(req_size)};

    seqdet_history #(.ADDR_W(ADDR_W)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .clear      (flush),
        .in_addr    (req_addr),
        .in_kind    (cur_kind),
        .hist_valid (hist_valid),
        .hist_addr  (hist_addr),
        .hist_kind  (hist_kind)
    );

    seqdet_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .prev_valid  (hist_valid),
        .prev_addr   (hist_addr),
        .prev_kind   (hist_kind),
        .force_break (flush),
        .cur_addr    (req_addr),
        .cur_kind    (cur_kind),
        .follows     (follows)
    );

    assign seq_flag = accept && follows;
    assign restart  = accept && !follows;

    // R11: one decision per accepted access
    a_r11_one_decision: assert property (@(posedge clk) disable iff (rst)
        accept |-> $countones({seq_flag, restart}) == 1);

    // R7: quiet outputs without an accepted access
    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !accept |-> !(seq_flag || restart));

    // R6: first access after reset restarts
    a_r6_first_restart: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && accept) |-> restart);

    // R2: direction change breaks the burst
    a_r2_dir_break: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write != hist_kind.is_write) |-> restart);

    // R3: size change breaks the burst
    a_r3_size_break: assert property (@(posedge clk) disable iff (rst)
        (accept && req_size != hist_kind.size) |-> restart);

    // R10: reserved size always restarts
    a_r10_rsvd_restart: assert property (@(posedge clk) disable iff (rst)
        (accept && req_size == 2'b11) |-> restart);

    // R8: flush with an access restarts
    a_r8_flush_restart: assert property (@(posedge clk) disable iff (rst)
        (accept && flush) |-> restart);

endmodule

// File: tb/seq_access_detector_tb.sv
module seq_access_detector_tb;

    localparam int unsigned ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              req_write;
    logic [1:0]        req_size;
    logic              flush;
    logic              seq_flag;
    logic              restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seq_access_detector #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_size  (req_size),
        .flush     (flush),
        .seq_flag  (seq_flag),
        .restart   (restart)
    );

    task automatic check(input string tag, input logic exp_s, input logic exp_r);
        checks++;
        if (seq_flag !== exp_s || restart !== exp_r) begin
            fails++;
            $display("FAIL %s: seq=%0b restart=%0b expected seq=%0b restart=%0b",
                     tag, seq_flag, restart, exp_s, exp_r);
        end
    endtask

    // present one cycle of stimulus and check the same-cycle decision
    task automatic cyc(input logic v, input logic rdy, input logic [ADDR_W-1:0] a,
                       input logic w, input logic [1:0] s, input logic fl,
                       input logic exp_s, input logic exp_r, input string tag);
        @(negedge clk);
        req_valid = v; req_ready = rdy; req_addr = a;
        req_write = w; req_size = s; flush = fl;
        #1;
        check(tag, exp_s, exp_r);
    endtask

    task automatic acc(input logic [ADDR_W-1:0] a, input logic w, input logic [1:0] s,
                       input logic exp_s, input string tag);
        cyc(1'b1, 1'b1, a, w, s, 1'b0, exp_s, !exp_s, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_ready = 1'b1; flush = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; req_ready = 1'b1; flush = 1'b0;
        req_addr = '0; req_write = 1'b0; req_size = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1 check("R7 idle after reset", 1'b0, 1'b0);
        acc(32'h100, 1'b0, 2'b00, 1'b0, "R6 first access restarts");
    endtask

    task automatic t_steps();
        acc(32'h101, 1'b0, 2'b00, 1'b1, "R1 R5 byte step");
        acc(32'h200, 1'b0, 2'b01, 1'b0, "R3 size change to half");
        acc(32'h202, 1'b0, 2'b01, 1'b1, "R5 half step");
        acc(32'h204, 1'b0, 2'b10, 1'b0, "R3 size change to word");
        acc(32'h208, 1'b0, 2'b10, 1'b1, "R5 word step");
        acc(32'h20C, 1'b1, 2'b10, 1'b0, "R2 read to write");
        acc(32'h210, 1'b1, 2'b10, 1'b1, "R1 write burst");
        acc(32'h214, 1'b0, 2'b10, 1'b0, "R2 write to read");
    endtask

    task automatic t_gaps();
        acc(32'h21C, 1'b0, 2'b10, 1'b0, "R4 forward gap");
        acc(32'h218, 1'b0, 2'b10, 1'b0, "R4 backward step");
        acc(32'h218, 1'b0, 2'b10, 1'b0, "R4 repeated address");
        acc(32'h21C, 1'b0, 2'b10, 1'b1, "R1 resumes after gap");
    endtask

    task automatic t_stall();
        cyc(1'b1, 1'b0, 32'h220, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R7 not ready quiet");
        cyc(1'b1, 1'b0, 32'h900, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, "R7 stalled odd access quiet");
        cyc(1'b0, 1'b1, 32'h220, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R7 no valid quiet");
        acc(32'h220, 1'b0, 2'b10, 1'b1, "R7 stall left record intact");
    endtask

    task automatic t_flush();
        cyc(1'b0, 1'b1, 32'h0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, "R8 flush alone quiet");
        acc(32'h224, 1'b0, 2'b10, 1'b0, "R8 access after flush restarts");
        acc(32'h228, 1'b0, 2'b10, 1'b1, "R8 chain resumes");
        cyc(1'b1, 1'b1, 32'h22C, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, "R8 flush with access restarts");
        acc(32'h230, 1'b0, 2'b10, 1'b1, "R8 flushed access was recorded");
    endtask

    task automatic t_wrap();
        acc(32'hFFFF_FFFF, 1'b0, 2'b00, 1'b0, "R4 jump to top");
        acc(32'h0000_0000, 1'b0, 2'b00, 1'b0, "R9 byte wrap restarts");
        acc(32'h0000_0001, 1'b0, 2'b00, 1'b1, "R1 after byte wrap");
        acc(32'hFFFF_FFFC, 1'b0, 2'b10, 1'b0, "R3 word at top");
        acc(32'h0000_0000, 1'b0, 2'b10, 1'b0, "R9 word wrap restarts");
        acc(32'hFFFF_FFFE, 1'b0, 2'b01, 1'b0, "R3 half at top");
        acc(32'h0000_0000, 1'b0, 2'b01, 1'b0, "R9 half wrap restarts");
    endtask

    task automatic t_rsvd();
        acc(32'h40, 1'b1, 2'b00, 1'b0, "R2 new write chain");
        acc(32'h41, 1'b1, 2'b11, 1'b0, "R10 reserved size restarts");
        acc(32'h41, 1'b1, 2'b11, 1'b0, "R10 reserved twice restarts");
        acc(32'h41, 1'b1, 2'b00, 1'b0, "R10 access after reserved restarts");
        acc(32'h42, 1'b1, 2'b00, 1'b1, "R11 chain after reserved");
    endtask

    task automatic t_mid_reset();
        do_reset();
        acc(32'h43, 1'b1, 2'b00, 1'b0, "R6 reset forgets record");
        acc(32'h44, 1'b1, 2'b00, 1'b1, "R11 sequential after reset");
        idle();
    endtask

    initial begin
        t_reset();
        t_steps();
        t_gaps();
        t_stall();
        t_flush();
        t_wrap();
        t_rsvd();
        t_mid_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule